// File: doc/BRIEF.md
# Serial Flash Byte Write Controller

This block turns a one-byte write request on a parallel user port into the command sequence that a serial NOR flash expects on a single-lane SPI link. The user places an address and a data byte on the port, then raises `write` together with `wren`. On the next clock edge the block captures the request and raises `busy`. It then reads the flash status register and compares the captured address with the write-protected region that the status register reports.

If the address is protected, the request is dropped. `busy` falls and `illegal_write` pulses for two cycles, and no write command reaches the flash. Otherwise the block sends a write-enable frame. It then sends one frame that holds the program opcode, the address and the data byte. After that it polls the status register until the flash reports that its internal program cycle is over, and only then releases `busy`.

If `write` and `wren` are still high when the block returns to idle, they are taken as a new request. The user must lower them before `busy` falls.

Top module: `flash_byte_writer`

## Requirements
- R1: `write`, `wren`, `wr_addr` and `wr_data` are sampled on the rising clock edge. When both strobes are high in idle, `busy` is 1 one cycle later. The byte and the 24-bit address that are programmed are the values present at that edge, even if the port changes afterwards.
- R2: A request with `wren` or `write` low starts nothing. `busy` stays 0 and `spi_cs_n` stays 1.
- R3: Before any write command, the status register is read with opcode 0x05 (8 opcode bits, then 8 status bits in). Its bits [4:2] form a guard level g. The address is protected when g is non-zero and, within a MEM_AW-bit array, the top 7-g address bits are all ones. For g = 7 every address is protected.
- R4: For a protected address, no write-enable or program frame is sent. `busy` falls in the same cycle that `illegal_write` rises, and `illegal_write` stays high for exactly two cycles.
- R5: For an unprotected address, the block sends opcode 0x06 alone in one frame. It then sends opcode 0x02, the 24-bit address MSB first and the data byte MSB first, all in one 40-bit frame.
- R6: After the program frame, the block repeatedly reads the status register. `busy` stays high until a read returns bit 0 (write in progress) as 0, and it falls right after that frame ends.
- R7: Strobes that are still high when `busy` falls are accepted again, and a second full write is performed.
- R8: SPI mode 0 is used. `spi_sck` idles low whenever `spi_cs_n` is high, data is sampled on the rising `spi_sck` edge, and `spi_cs_n` stays high for at least 2*SCK_HALF clock cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| write | input | 1 | Write request strobe |
| wren | input | 1 | Write permission; a request needs both strobes |
| wr_data | input | 8 | Byte to program |
| wr_addr | input | 24 | Target byte address |
| busy | output | 1 | A request is in progress |
| illegal_write | output | 1 | Two-cycle pulse when a request hits a protected region |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
`busy` is due exactly one cycle after the edge that samples a request. The bench raises the strobes on a falling edge and reads `busy` on the next falling edge. `illegal_write` appears in the cycle that `busy` drops after the status frame, and its width is counted on successive falling edges. The programmed byte, the frame count and the number of status polls are compared only after `busy` is low again. At that point every frame has been closed by a rising `spi_cs_n`, which the flash model in the bench uses to commit each frame.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;

  localparam int FRAME_W = 40;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SR_CHK, ST_CANCEL, ST_WEN, ST_PROG, ST_POLL
  } ctl_state_t;

  // Guard level g protects the top 1/2^(7-g) of a 2^aw byte array.
  function automatic logic in_guard(input logic [23:0] addr,
                                    input logic [2:0]  g,
                                    input int          aw);
    logic [24:0] span, size, base, a;
    if (g == 3'd0) return 1'b0;
    span = 25'd1 << aw;
    size = span >> (3'd7 - g);
    base = span - size;
    a    = {1'b0, addr} & (span - 25'd1);
    return a >= base;
  endfunction

endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter
  import flash_wr_pkg::*;
#(
  parameter int SCK_HALF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx,
  input  logic [BCNT_W-1:0]  nbits,
  output logic               done,
  output logic [7:0]         rx_byte,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);

  localparam int GAP   = 2 * SCK_HALF;
  localparam int DIV_W = $clog2(GAP + 1);

  typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_GAP} sh_state_t;

  sh_state_t          st;
  logic [FRAME_W-1:0] sr;
  logic [BCNT_W-1:0]  bits;
  logic [DIV_W-1:0]   div;

  wire half_end = (div == DIV_W'(SCK_HALF - 1));
  wire gap_end  = (div == DIV_W'(GAP - 1));

  assign mosi = sr[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SH_IDLE;
      sr      <= '0;
      bits    <= '0;
      div     <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: if (start) begin
          sr   <= tx;
          bits <= nbits;
          div  <= '0;
          cs_n <= 1'b0;
          st   <= SH_RUN;
        end
        SH_RUN: begin
          if (half_end) begin
            div <= '0;
            if (!sck) begin
              sck     <= 1'b1;
              rx_byte <= {rx_byte[6:0], miso};
            end else begin
              sck  <= 1'b0;
              sr   <= sr << 1;
              bits <= bits - 1'b1;
              if (bits == BCNT_W'(1)) begin
                cs_n <= 1'b1;
                st   <= SH_GAP;
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        default: begin
          if (gap_end) begin
            div  <= '0;
            done <= 1'b1;
            st   <= SH_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_byte_writer.sv
module flash_byte_writer
  import flash_wr_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int MEM_AW   = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        write,
  input  logic        wren,
  input  logic [7:0]  wr_data,
  input  logic [23:0] wr_addr,
  output logic        busy,
  output logic        illegal_write,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam logic [BCNT_W-1:0] N_SR = BCNT_W'(16);
  localparam logic [BCNT_W-1:0] N_WE = BCNT_W'(8);
  localparam logic [BCNT_W-1:0] N_PP = BCNT_W'(FRAME_W);

  ctl_state_t         st;
  logic [23:0]        a_q;
  logic [7:0]         d_q;
  logic               ill_cnt;
  logic               sh_start;
  logic [FRAME_W-1:0] sh_tx;
  logic [BCNT_W-1:0]  sh_nbits;
  logic               sh_done;
  logic [7:0]         sh_rx;

  // Named internal events, also used by the bound checker.
  wire ev_accept     = (st == ST_IDLE) && write && wren;
  wire ev_blocked    = (st == ST_SR_CHK) && sh_done && in_guard(a_q, sh_rx[4:2], MEM_AW);
  wire ev_poll_clear = (st == ST_POLL) && sh_done && !sh_rx[0];

  flash_spi_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx      (sh_tx),
    .nbits   (sh_nbits),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      a_q           <= '0;
      d_q           <= '0;
      busy          <= 1'b0;
      illegal_write <= 1'b0;
      ill_cnt       <= 1'b0;
      sh_start      <= 1'b0;
      sh_tx         <= '0;
      sh_nbits      <= '0;
    end else begin
      sh_start <= 1'b0;
      case (st)
        ST_IDLE: if (ev_accept) begin
          a_q      <= wr_addr;
          d_q      <= wr_data;
          busy     <= 1'b1;
          sh_start <= 1'b1;
          sh_tx    <= {OP_RDSR, 32'h0};
          sh_nbits <= N_SR;
          st       <= ST_SR_CHK;
        end
        ST_SR_CHK: if (sh_done) begin
          if (ev_blocked) begin
            busy          <= 1'b0;
            illegal_write <= 1'b1;
            ill_cnt       <= 1'b0;
            st            <= ST_CANCEL;
          end else begin
            sh_start <= 1'b1;
            sh_tx    <= {OP_WREN, 32'h0};
            sh_nbits <= N_WE;
            st       <= ST_WEN;
          end
        end
        ST_CANCEL: begin
          if (ill_cnt) begin
            illegal_write <= 1'b0;
            st            <= ST_IDLE;
          end else begin
            ill_cnt <= 1'b1;
          end
        end
        ST_WEN: if (sh_done) begin
          sh_start <= 1'b1;
          sh_tx    <= {OP_PP, a_q, d_q};
          sh_nbits <= N_PP;
          st       <= ST_PROG;
        end
        ST_PROG: if (sh_done) begin
          sh_start <= 1'b1;
          sh_tx    <= {OP_RDSR, 32'h0};
          sh_nbits <= N_SR;
          st       <= ST_POLL;
        end
        default: if (sh_done) begin
          if (ev_poll_clear) begin
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            sh_start <= 1'b1;
            sh_tx    <= {OP_RDSR, 32'h0};
            sh_nbits <= N_SR;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_byte_writer_chk.sv
module flash_byte_writer_chk #(
  parameter int SCK_HALF = 2
) (
  input logic clk,
  input logic rst_n,
  input logic write,
  input logic wren,
  input logic busy,
  input logic illegal_write,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic ev_accept,
  input logic ev_blocked,
  input logic ev_poll_clear
);

  localparam int GAP  = 2 * SCK_HALF;
  localparam int HL_W = $clog2(GAP + 1);

  logic [HL_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= HL_W'(GAP);
    else if (!spi_cs_n) hi_len <= '0;
    else if (hi_len != HL_W'(GAP)) hi_len <= hi_len + 1'b1;
  end

  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(write && wren && ev_accept)); // R1
  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n); // R2
  AST_BLOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blocked |=> $rose(illegal_write)); // R3
  AST_CANCEL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_write |-> !busy); // R4
  AST_CANCEL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal_write) |=> illegal_write ##1 !illegal_write); // R4
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(ev_poll_clear) || illegal_write)); // R6
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R8
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_len >= HL_W'(GAP))); // R8

endmodule

bind flash_byte_writer flash_byte_writer_chk #(.SCK_HALF(SCK_HALF)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .write         (write),
  .wren          (wren),
  .busy          (busy),
  .illegal_write (illegal_write),
  .spi_sck       (spi_sck),
  .spi_cs_n      (spi_cs_n),
  .ev_accept     (ev_accept),
  .ev_blocked    (ev_blocked),
  .ev_poll_clear (ev_poll_clear)
);

// File: tb/flash_byte_writer_tb.sv
module flash_byte_writer_tb;

  localparam int SCK_HALF = 2;
  localparam int MEM_AW   = 8;
  localparam int POLLS    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic write = 1'b0, wren = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [23:0] wr_addr = '0;
  logic busy, illegal_write, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #10 clk = ~clk;

  flash_byte_writer #(.SCK_HALF(SCK_HALF), .MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .write(write), .wren(wren),
    .wr_data(wr_data), .wr_addr(wr_addr), .busy(busy),
    .illegal_write(illegal_write), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [2:0]  fl_bp = 3'd0;
  logic        fl_wip = 1'b0, fl_wel = 1'b0, last_wren = 1'b0, seq_err = 1'b0;
  int          nb = 0, n_frames = 0, n_pp = 0, reads_after_pp = 0, reads_left = 0;
  logic [39:0] fsh = '0;
  logic [7:0]  fop = '0;
  logic [23:0] pp_addr = '0;
  logic [7:0]  pp_data = '0;
  wire  [7:0]  fl_status = {3'b000, fl_bp, fl_wel, fl_wip};

  always @(negedge spi_cs_n) begin nb = 0; fsh = '0; fop = '0; end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    fsh = {fsh[38:0], spi_mosi};
    nb++;
    if (nb == 8) fop = fsh[7:0];
  end
  always @(negedge spi_sck)
    spi_miso <= (!spi_cs_n && fop == 8'h05 && nb >= 8 && nb < 16) ? fl_status[15 - nb] : 1'b0;
  always @(posedge spi_cs_n) if (rst_n) begin
    n_frames++;
    if (nb == 8 && fop == 8'h06) begin
      fl_wel = 1'b1; last_wren = 1'b1;
    end else if (nb == 16 && fop == 8'h05) begin
      reads_after_pp++;
      if (fl_wip) begin
        reads_left--;
        if (reads_left == 0) fl_wip = 1'b0;
      end
      last_wren = 1'b0;
    end else if (nb == 40 && fop == 8'h02) begin
      if (!fl_wel || !last_wren) seq_err = 1'b1;
      n_pp++;
      pp_addr = fsh[31:8]; pp_data = fsh[7:0];
      fl_wip = 1'b1; fl_wel = 1'b0; last_wren = 1'b0;
      reads_left = POLLS; reads_after_pp = 0;
    end else begin
      seq_err = 1'b1; last_wren = 1'b0;
    end
  end

  // ---------------- R8 bus monitors ----------------
  int hi_run = 1000, min_gap = 1000, sck_bad = 0;
  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n && spi_sck) sck_bad++;
    if (spi_cs_n) hi_run++;
    else begin
      if (hi_run != 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
  end

  // Expected protection, restated as "top 7-g bits all ones".
  function automatic bit exp_guard(input logic [7:0] a8, input logic [2:0] g);
    int k;
    if (g == 0) return 0;
    k = 7 - g;
    if (k == 0) return 1;
    return (int'(a8) >> (MEM_AW - k)) == ((1 << k) - 1);
  endfunction

  task automatic do_write(input logic [23:0] a, input logic [7:0] d, input logic [2:0] g);
    int f0, p0, ill;
    bit prot;
    prot = exp_guard(a[7:0], g);
    fl_bp = g;
    f0 = n_frames; p0 = n_pp; ill = 0;
    @(negedge clk);
    wr_addr = a; wr_data = d; write = 1'b1; wren = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1", "busy one cycle after request", busy, 1);
    write = 1'b0; wren = 1'b0; wr_addr = ~a; wr_data = ~d;
    while (busy) begin
      @(negedge clk);
      if (illegal_write) ill++;
    end
    repeat (4) begin
      @(negedge clk);
      if (illegal_write) ill++;
    end
    if (prot) begin
      chk(ill == 2, "R4", "illegal_write width", ill, 2);
      chk(n_pp == p0, "R3", "program frames on protected address", n_pp - p0, 0);
      chk(n_frames - f0 == 1, "R4", "frames on protected address", n_frames - f0, 1);
    end else begin
      chk(ill == 0, "R3", "illegal_write on open address", ill, 0);
      chk(n_pp - p0 == 1, "R5", "program frames", n_pp - p0, 1);
      chk(pp_addr == a, "R1", "programmed address", pp_addr, a);
      chk(pp_data == d, "R1", "programmed data", pp_data, d);
      chk(n_frames - f0 == 4 + POLLS, "R5", "frame count", n_frames - f0, 4 + POLLS);
      chk(reads_after_pp == POLLS + 1, "R6", "status polls", reads_after_pp, POLLS + 1);
      chk(fl_wip == 1'b0, "R6", "write in progress at busy fall", fl_wip, 0);
      chk(seq_err == 1'b0, "R5", "command order", seq_err, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int f0, p0, bz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !illegal_write, "R2", "reset outputs", {busy, illegal_write}, 0);
    chk(spi_cs_n && !spi_sck, "R8", "reset bus idle", {spi_cs_n, spi_sck}, 2);

    // R2: one strobe alone starts nothing
    f0 = n_frames; bz = 0;
    wr_addr = 24'h123456; wr_data = 8'h5A;
    write = 1'b1; wren = 1'b0;
    repeat (40) begin @(negedge clk); if (busy || !spi_cs_n) bz++; end
    write = 1'b0; wren = 1'b1;
    repeat (40) begin @(negedge clk); if (busy || !spi_cs_n) bz++; end
    wren = 1'b0;
    chk(bz == 0, "R2", "activity without both strobes", bz, 0);
    chk(n_frames == f0, "R2", "frames without both strobes", n_frames - f0, 0);

    // R3 R4 R5 R6: sweep guard levels and addresses
    for (int g = 0; g < 8; g++) begin
      for (int j = 0; j < 16; j++)
        do_write({8'hC3 ^ 8'(j), 8'(8'h5A + g), 8'(j * 17)}, 8'(j * 29 + g), 3'(g));
      if (g != 0) begin
        int b;
        b = 256 - (256 >> (7 - g));
        do_write({8'h81, 8'(g), 8'(b)}, 8'hA5, 3'(g));
        if (b > 0) do_write({8'h7E, 8'(g), 8'(b - 1)}, 8'h3C, 3'(g));
      end
    end

    // R7: strobes held past busy fall cause a second write
    fl_bp = 3'd0;
    p0 = n_pp;
    @(negedge clk);
    wr_addr = 24'hABCD12; wr_data = 8'h77; write = 1'b1; wren = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R7", "re-accept after busy fall", busy, 1);
    write = 1'b0; wren = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_pp - p0 == 2, "R7", "writes with held strobes", n_pp - p0, 2);
    chk(pp_data == 8'h77, "R7", "second write data", pp_data, 8'h77);

    chk(sck_bad == 0, "R8", "sck high while deselected", sck_bad, 0);
    chk(min_gap >= 2 * SCK_HALF, "R8", "chip-select gap", min_gap, 2 * SCK_HALF);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule